// File: doc/BRIEF.md
# Self-Synchronizing Multi-Channel NCO Bank

This block holds four numerically controlled oscillator channels. Each channel produces a 32-bit phase word and an amplitude value. When the coherent option is set, every channel takes its phase from one shared reference counter, so the phase difference between any two channels depends only on their programmed settings. An internal timer raises a sync event every programmed number of cycles. The block needs no external sync pulse.

Software writes frequency, phase offset and amplitude into configuration registers. Those values reach the working registers that drive the outputs only on a sync event. Each sync event copies the configuration again. A working register that has been corrupted is therefore repaired within one sync period. A test-only force port lets a bench corrupt a working register or the shared counter.

The sync timer is a state machine with three states. TMR_IDLE is the disabled state. It moves to TMR_COUNT when self-sync is on and the period is non-zero, or to TMR_FIRE if the period is 1. TMR_COUNT counts up to period-1 and then moves to TMR_FIRE. TMR_FIRE is the one-cycle sync event. From it the timer returns to TMR_COUNT, or stays in TMR_FIRE when the period is 1. Any state falls back to TMR_IDLE when sync is disabled. The bank state machine has two states, BANK_EMPTY and BANK_LIVE, and moves from BANK_EMPTY to BANK_LIVE on the first sync event.

Mode bits, written through a separate port: bit 0 = accumulator clear on sync, bit 1 = coherent (shared counter), bit 2 = self-sync enable, bit 3 = amplitude scrub (DDS). Field codes on the register and force ports: 0 = frequency, 1 = phase offset, 2 = amplitude.

Top module: `nco_bank_selfsync`

## Requirements
- R1: While reset is active and after it, until the first sync event, every phase output, every amplitude output and every valid flag is 0.
- R2: The valid flags rise exactly two cycles after the timer enters TMR_FIRE for the first time. When a period P is set before the mode write that enables self-sync, this is P+2 cycles after that mode write. Once high, the valid flags stay high.
- R3: With coherent mode on (mode bit 1), the phase output of channel k equals ref × freq_k + offset_k modulo 2^32, where ref is the shared counter and freq_k and offset_k are the channel's working values.
- R4: The shared counter advances by exactly one each cycle unless it is forced or cleared.
- R5: With coherent mode off, each channel's phase output advances by its working frequency word every cycle (private accumulator plus offset).
- R6: Sync events recur every P cycles when mode bit 2 is set and P is non-zero. When P is 0 or bit 2 is clear there are none, and a corrupted working value then persists.
- R7: A configuration write changes the working value only at the next sync event. Until then the outputs keep the old setting.
- R8: A sync event restores each channel's working frequency and phase offset from its configuration registers.
- R9: The first sync event always loads the amplitude. Later sync events restore the amplitude only when mode bit 3 (DDS) is set. With bit 3 clear, a corrupted amplitude persists.
- R10: With mode bit 0 set, a sync event clears the shared counter and every accumulator. With bit 0 clear, they keep running.
- R11: When the shared counter is forced to a new value, every channel's phase jumps together, and the coherent relation of R3 still holds for all channels.
- R12: The outputs are registered. A change to a working value or to the shared counter reaches the outputs one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_ch | input | 2 | Channel selected by the configuration write |
| cfg_field | input | 2 | Field code (0 frequency, 1 offset, 2 amplitude) |
| cfg_data | input | 32 | Configuration write data; amplitude uses the low 16 bits |
| mode_we | input | 1 | Mode register write strobe |
| mode_data | input | 4 | Mode bits: 0 clear on sync, 1 coherent, 2 self-sync, 3 DDS |
| sync_period | input | 16 | Cycles between sync events; 0 disables them |
| frc_en | input | 1 | Test force strobe |
| frc_sel | input | 3 | Force target: 0 to 3 channel, 4 shared counter |
| frc_field | input | 2 | Field code of the forced channel value |
| frc_data | input | 32 | Forced value |
| phase_o | output | 128 | Phase words, channel k at bits 32k+31 down to 32k |
| amp_o | output | 64 | Amplitudes, channel k at bits 16k+15 down to 16k |
| valid_o | output | 4 | Per-channel valid flags |

## Verification
A corrupted working frequency or offset shows up in the phase of the affected channel one cycle after the corruption. The bench measures it against a probe channel set to frequency 1 and offset 0, whose phase output is the shared counter itself. The same error must disappear at the outputs one cycle after the next sync event, so a missing repair is visible no later than one period plus two cycles. A corrupted shared counter is visible in the probe on the next cycle, while the coherent relation across the channels must stay intact. A timer that runs slow or fast shifts the first rise of valid away from P+2, and also shifts the counter values seen under clear-on-sync away from 0 through P-1.

// File: rtl/nco_bank_pkg.sv
package nco_bank_pkg;

    typedef enum logic [1:0] {
        FLD_FREQ = 2'd0,
        FLD_OFFS = 2'd1,
        FLD_AMP  = 2'd2,
        FLD_NONE = 2'd3
    } fld_e;

    typedef enum logic [1:0] {
        TMR_IDLE  = 2'd0,
        TMR_COUNT = 2'd1,
        TMR_FIRE  = 2'd2
    } tmr_state_e;

    typedef enum logic {
        BANK_EMPTY = 1'b0,
        BANK_LIVE  = 1'b1
    } bank_state_e;

    typedef struct packed {
        logic dds;        // bit 3: amplitude scrub on sync
        logic self_sync;  // bit 2: internal timer enable
        logic self_coh;   // bit 1: phase from shared counter
        logic acc_rst;    // bit 0: sync clears counter and accumulators
    } mode_t;

endpackage

// File: rtl/nco_cfg_file.sv
module nco_cfg_file
    import nco_bank_pkg::*;
#(
    parameter int NUM_CH  = 4,
    parameter int PHASE_W = 32,
    parameter int AMP_W   = 16,
    localparam int CH_W   = $clog2(NUM_CH)
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             cfg_we,
    input  logic [CH_W-1:0]                  cfg_ch,
    input  logic [1:0]                       cfg_field,
    input  logic [PHASE_W-1:0]               cfg_data,
    input  logic                             mode_we,
    input  logic [3:0]                       mode_data,
    output logic [NUM_CH-1:0][PHASE_W-1:0]   cfg_freq,
    output logic [NUM_CH-1:0][PHASE_W-1:0]   cfg_offs,
    output logic [NUM_CH-1:0][AMP_W-1:0]     cfg_amp,
    output mode_t                            mode_q
);

    fld_e wr_fld;
    assign wr_fld = fld_e'(cfg_field);

    for (genvar k = 0; k < NUM_CH; k++) begin : g_chan_regs
        logic hit;
        assign hit = cfg_we && (cfg_ch == CH_W'(k));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                cfg_freq[k] <= '0;
                cfg_offs[k] <= '0;
                cfg_amp[k]  <= '0;
            end else if (hit) begin
                unique case (wr_fld)
                    FLD_FREQ: cfg_freq[k] <= cfg_data;
                    FLD_OFFS: cfg_offs[k] <= cfg_data;
                    FLD_AMP:  cfg_amp[k]  <= cfg_data[AMP_W-1:0];
                    default:  ;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= '0;
        end else if (mode_we) begin
            mode_q <= mode_t'(mode_data);
        end
    end

endmodule

// File: rtl/nco_sync_timer.sv
module nco_sync_timer
    import nco_bank_pkg::*;
#(
    parameter int PER_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic [PER_W-1:0] period,
    output logic             sync_evt
);

    tmr_state_e       state_q, state_n;
    logic [PER_W-1:0] cnt_q, cnt_n;
    logic             run;

    assign run = enable && (period != '0);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= TMR_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_n;
            cnt_q   <= cnt_n;
        end
    end

    // next state
    always_comb begin
        state_n = state_q;
        cnt_n   = cnt_q;
        if (!run) begin
            state_n = TMR_IDLE;
            cnt_n   = '0;
        end else begin
            unique case (state_q)
                TMR_IDLE, TMR_FIRE: begin
                    state_n = (period == PER_W'(1)) ? TMR_FIRE : TMR_COUNT;
                    cnt_n   = PER_W'(1);
                end
                TMR_COUNT: begin
                    if (cnt_q >= period - 1'b1) begin
                        state_n = TMR_FIRE;
                    end else begin
                        cnt_n = cnt_q + 1'b1;
                    end
                end
                default: begin
                    state_n = TMR_IDLE;
                    cnt_n   = '0;
                end
            endcase
        end
    end

    // outputs
    always_comb begin
        sync_evt = (state_q == TMR_FIRE);
    end

endmodule

// File: rtl/nco_lane.sv
module nco_lane
    import nco_bank_pkg::*;
#(
    parameter int PHASE_W = 32,
    parameter int AMP_W   = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sync_evt,
    input  logic               first_load,
    input  logic               acc_clr,
    input  logic               dds_mode,
    input  logic               self_coh,
    input  logic [PHASE_W-1:0] ref_cnt,
    input  logic [PHASE_W-1:0] cfg_freq,
    input  logic [PHASE_W-1:0] cfg_offs,
    input  logic [AMP_W-1:0]   cfg_amp,
    input  logic               frc_hit,
    input  fld_e               frc_field,
    input  logic [PHASE_W-1:0] frc_data,
    output logic [PHASE_W-1:0] phase_q,
    output logic [AMP_W-1:0]   amp_q,
    output logic [AMP_W-1:0]   work_amp
);

    logic [PHASE_W-1:0] wf_q, wo_q, acc_q, phase_n;
    logic [AMP_W-1:0]   wa_q;

    // working registers: sync reload has priority over a forced upset
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wf_q <= '0;
            wo_q <= '0;
            wa_q <= '0;
        end else if (sync_evt) begin
            wf_q <= cfg_freq;
            wo_q <= cfg_offs;
            if (dds_mode || first_load) begin
                wa_q <= cfg_amp;
            end
        end else if (frc_hit) begin
            unique case (frc_field)
                FLD_FREQ: wf_q <= frc_data;
                FLD_OFFS: wo_q <= frc_data;
                FLD_AMP:  wa_q <= frc_data[AMP_W-1:0];
                default:  ;
            endcase
        end
    end

    // private accumulator used when the shared counter is not selected
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q <= '0;
        end else if (acc_clr) begin
            acc_q <= '0;
        end else begin
            acc_q <= acc_q + wf_q;
        end
    end

    always_comb begin
        if (self_coh) begin
            phase_n = ref_cnt * wf_q + wo_q;
        end else begin
            phase_n = acc_q + wo_q;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase_q <= '0;
            amp_q   <= '0;
        end else begin
            phase_q <= phase_n;
            amp_q   <= wa_q;
        end
    end

    assign work_amp = wa_q;

endmodule

// File: rtl/nco_bank_selfsync.sv
module nco_bank_selfsync
    import nco_bank_pkg::*;
#(
    parameter int NUM_CH  = 4,
    parameter int PHASE_W = 32,
    parameter int AMP_W   = 16,
    parameter int PER_W   = 16,
    localparam int CH_W   = $clog2(NUM_CH),
    localparam int SEL_W  = $clog2(NUM_CH + 1)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      cfg_we,
    input  logic [CH_W-1:0]           cfg_ch,
    input  logic [1:0]                cfg_field,
    input  logic [PHASE_W-1:0]        cfg_data,
    input  logic                      mode_we,
    input  logic [3:0]                mode_data,
    input  logic [PER_W-1:0]          sync_period,
    input  logic                      frc_en,
    input  logic [SEL_W-1:0]          frc_sel,
    input  logic [1:0]                frc_field,
    input  logic [PHASE_W-1:0]        frc_data,
    output logic [NUM_CH*PHASE_W-1:0] phase_o,
    output logic [NUM_CH*AMP_W-1:0]   amp_o,
    output logic [NUM_CH-1:0]         valid_o
);

    logic [NUM_CH-1:0][PHASE_W-1:0] cfg_freq, cfg_offs;
    logic [NUM_CH-1:0][AMP_W-1:0]   cfg_amp, work_amp;
    mode_t                          mode_q;
    logic                           sync_evt, acc_clr, frc_ref;
    logic [PHASE_W-1:0]             ref_cnt;
    bank_state_e                    bank_q, bank_n;

    nco_cfg_file #(
        .NUM_CH (NUM_CH),
        .PHASE_W(PHASE_W),
        .AMP_W  (AMP_W)
    ) u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_we   (cfg_we),
        .cfg_ch   (cfg_ch),
        .cfg_field(cfg_field),
        .cfg_data (cfg_data),
        .mode_we  (mode_we),
        .mode_data(mode_data),
        .cfg_freq (cfg_freq),
        .cfg_offs (cfg_offs),
        .cfg_amp  (cfg_amp),
        .mode_q   (mode_q)
    );

    nco_sync_timer #(
        .PER_W(PER_W)
    ) u_tmr (
        .clk     (clk),
        .rst_n   (rst_n),
        .enable  (mode_q.self_sync),
        .period  (sync_period),
        .sync_evt(sync_evt)
    );

    assign acc_clr = sync_evt && mode_q.acc_rst;
    assign frc_ref = frc_en && (frc_sel == SEL_W'(NUM_CH));

    // shared phase reference counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ref_cnt <= '0;
        end else if (frc_ref) begin
            ref_cnt <= frc_data;
        end else if (acc_clr) begin
            ref_cnt <= '0;
        end else begin
            ref_cnt <= ref_cnt + 1'b1;
        end
    end

    // bank state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bank_q <= BANK_EMPTY;
        end else begin
            bank_q <= bank_n;
        end
    end

    always_comb begin
        bank_n = bank_q;
        unique case (bank_q)
            BANK_EMPTY: if (sync_evt) bank_n = BANK_LIVE;
            BANK_LIVE:  bank_n = BANK_LIVE;
            default:    bank_n = BANK_EMPTY;
        endcase
    end

    // bank outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid_o <= '0;
        end else begin
            valid_o <= {NUM_CH{bank_q == BANK_LIVE}};
        end
    end

    for (genvar k = 0; k < NUM_CH; k++) begin : g_lane
        logic hit;
        assign hit = frc_en && (frc_sel == SEL_W'(k));

        nco_lane #(
            .PHASE_W(PHASE_W),
            .AMP_W  (AMP_W)
        ) u_lane (
            .clk       (clk),
            .rst_n     (rst_n),
            .sync_evt  (sync_evt),
            .first_load(bank_q == BANK_EMPTY),
            .acc_clr   (acc_clr),
            .dds_mode  (mode_q.dds),
            .self_coh  (mode_q.self_coh),
            .ref_cnt   (ref_cnt),
            .cfg_freq  (cfg_freq[k]),
            .cfg_offs  (cfg_offs[k]),
            .cfg_amp   (cfg_amp[k]),
            .frc_hit   (hit),
            .frc_field (fld_e'(frc_field)),
            .frc_data  (frc_data),
            .phase_q   (phase_o[k*PHASE_W +: PHASE_W]),
            .amp_q     (amp_o[k*AMP_W +: AMP_W]),
            .work_amp  (work_amp[k])
        );
    end

endmodule

// File: rtl/nco_bank_chk.sv
module nco_bank_chk #(
    parameter int NUM_CH  = 4,
    parameter int PHASE_W = 32,
    parameter int AMP_W   = 16,
    parameter int PER_W   = 16
) (
    input logic                           clk,
    input logic                           rst_n,
    input logic                           sync_evt,
    input logic [NUM_CH-1:0]              valid_o,
    input logic [PER_W-1:0]               sync_period,
    input logic                           mode_ss,
    input logic                           mode_ar,
    input logic                           frc_en,
    input logic                           frc_ref,
    input logic [PHASE_W-1:0]             ref_cnt,
    input logic [NUM_CH-1:0][AMP_W-1:0]   work_amp
);

    logic any_valid;
    assign any_valid = |valid_o;

    p_valid_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
        any_valid |=> any_valid);

    p_valid_after_sync_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(any_valid) |-> $past(sync_evt, 2));

    p_sync_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_evt && (sync_period > PER_W'(1))) |=> !sync_evt);

    p_sync_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ((sync_period == '0) || !mode_ss) |=> !sync_evt);

    p_ref_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!(sync_evt && mode_ar) && !frc_ref) |=> (ref_cnt == $past(ref_cnt) + PHASE_W'(1)));

    p_ref_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_evt && mode_ar && !frc_ref) |=> (ref_cnt == '0));

    p_amp_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!sync_evt && !frc_en) |=> $stable(work_amp));

endmodule

bind nco_bank_selfsync nco_bank_chk #(
    .NUM_CH (NUM_CH),
    .PHASE_W(PHASE_W),
    .AMP_W  (AMP_W),
    .PER_W  (PER_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .sync_evt   (sync_evt),
    .valid_o    (valid_o),
    .sync_period(sync_period),
    .mode_ss    (mode_q.self_sync),
    .mode_ar    (mode_q.acc_rst),
    .frc_en     (frc_en),
    .frc_ref    (frc_ref),
    .ref_cnt    (ref_cnt),
    .work_amp   (work_amp)
);

// File: tb/sim_nco_bank_selfsync.sv
module sim_nco_bank_selfsync;

    localparam int CLK_PERIOD = 10;
    localparam int NCH = 4;
    localparam int PW  = 32;
    localparam int AW  = 16;
    localparam int P   = 16;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              cfg_we;
    logic [1:0]        cfg_ch;
    logic [1:0]        cfg_field;
    logic [PW-1:0]     cfg_data;
    logic              mode_we;
    logic [3:0]        mode_data;
    logic [15:0]       sync_period;
    logic              frc_en;
    logic [2:0]        frc_sel;
    logic [1:0]        frc_field;
    logic [PW-1:0]     frc_data;
    logic [NCH*PW-1:0] phase_o;
    logic [NCH*AW-1:0] amp_o;
    logic [NCH-1:0]    valid_o;

    always #(CLK_PERIOD/2) clk = ~clk;

    nco_bank_selfsync u0 (
        .clk(clk), .rst_n(rst_n),
        .cfg_we(cfg_we), .cfg_ch(cfg_ch), .cfg_field(cfg_field), .cfg_data(cfg_data),
        .mode_we(mode_we), .mode_data(mode_data), .sync_period(sync_period),
        .frc_en(frc_en), .frc_sel(frc_sel), .frc_field(frc_field), .frc_data(frc_data),
        .phase_o(phase_o), .amp_o(amp_o), .valid_o(valid_o)
    );

    int n_cmp = 0;
    int n_bad = 0;
    int cyc   = 0;
    int cyc_v = 0;

    logic [PW-1:0] mf [NCH];
    logic [PW-1:0] mo [NCH];
    logic [AW-1:0] ma [NCH];

    typedef struct {
        string         req;
        int            ch;
        logic [PW-1:0] f;
        logic [PW-1:0] o;
    } coh_t;
    coh_t sb_q[$];

    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [PW-1:0] ph(input int k);
        return phase_o[k*PW +: PW];
    endfunction

    function automatic logic [AW-1:0] am(input int k);
        return amp_o[k*AW +: AW];
    endfunction

    task automatic check32(input string req, input string what,
                           input logic [PW-1:0] act, input logic [PW-1:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // driver: expected coherent relation items for channels 0..2 (channel 3 is the probe)
    task automatic push_coh(input string req);
        for (int k = 0; k < NCH - 1; k++) begin
            coh_t it;
            it.req = req; it.ch = k; it.f = mf[k]; it.o = mo[k];
            sb_q.push_back(it);
        end
    endtask

    // monitor: compares popped items against the outputs
    always @(negedge clk) begin
        while (sb_q.size() > 0) begin
            coh_t it;
            logic [PW-1:0] e;
            it = sb_q.pop_front();
            e  = ph(3) * it.f + it.o;
            check32(it.req, $sformatf("coherent phase ch%0d", it.ch), ph(it.ch), e);
        end
    end

    task automatic cfg_wr(input int ch, input int fld, input logic [PW-1:0] d);
        cfg_ch = 2'(ch); cfg_field = 2'(fld); cfg_data = d; cfg_we = 1'b1;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic mode_wr(input logic [3:0] m);
        mode_data = m; mode_we = 1'b1;
        @(negedge clk);
        mode_we = 1'b0;
    endtask

    task automatic force_wr(input int sel, input int fld, input logic [PW-1:0] d);
        frc_sel = 3'(sel); frc_field = 2'(fld); frc_data = d; frc_en = 1'b1;
        @(negedge clk);
        frc_en = 1'b0;
    endtask

    // advance to the negedge at position r within the sync period
    task automatic to_rel(input int r);
        do @(negedge clk); while (((cyc - cyc_v) % P) != r);
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        logic [PW-1:0] a [NCH];
        int n;
        rst_n = 1'b0; cfg_we = 0; cfg_ch = 0; cfg_field = 0; cfg_data = 0;
        mode_we = 0; mode_data = 0; sync_period = 0;
        frc_en = 0; frc_sel = 0; frc_field = 0; frc_data = 0;
        mf[0] = 32'h0100_0000; mo[0] = 32'h0000_0010; ma[0] = 16'h1111;
        mf[1] = 32'h0030_0000; mo[1] = 32'h4000_0000; ma[1] = 16'h2222;
        mf[2] = 32'hFFFF_0001; mo[2] = 32'h8000_0000; ma[2] = 16'h3333;
        mf[3] = 32'h0000_0001; mo[3] = 32'h0000_0000; ma[3] = 16'h4444;
        repeat (3) @(negedge clk);

        // R1: reset state
        check32("R1", "valid in reset", 32'(valid_o), 32'd0);
        check32("R1", "phases in reset", 32'(|phase_o), 32'd0);
        check32("R1", "amps in reset", 32'(|amp_o), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        sync_period = 16'(P);
        for (int k = 0; k < NCH; k++) begin
            cfg_wr(k, 0, mf[k]);
            cfg_wr(k, 1, mo[k]);
            cfg_wr(k, 2, 32'(ma[k]));
        end
        check32("R1", "no valid before sync", 32'(valid_o), 32'd0);
        check32("R1", "phase 0 before sync", 32'(|phase_o), 32'd0);

        // R2 / R6: first sync timing
        mode_wr(4'b1110);
        n = 0;
        while (valid_o[0] !== 1'b1 && n < 100) begin
            @(negedge clk);
            n++;
        end
        check32("R2", "cycles to valid", 32'(n), 32'(P + 2));
        check32("R2", "all valid", 32'(valid_o), 32'hF);
        cyc_v = cyc;

        // R9: first load brings amplitudes
        for (int k = 0; k < NCH; k++) check32("R9", "initial amplitude", 32'(am(k)), 32'(ma[k]));

        // R3: coherent relation
        push_coh("R3");
        @(negedge clk);
        push_coh("R3");

        // R4: shared counter step of one
        a[3] = ph(3);
        @(negedge clk);
        check32("R4", "probe step", ph(3) - a[3], 32'd1);

        // R7: configuration reaches outputs only at next sync
        to_rel(2);
        cfg_wr(0, 0, 32'h0200_0000);
        push_coh("R7");
        to_rel(1);
        mf[0] = 32'h0200_0000;
        push_coh("R7");

        // R8: frequency upset repaired
        to_rel(2);
        force_wr(1, 0, 32'h1234_5678);
        to_rel(5);
        check32("R8", "corrupted freq visible", ph(1), ph(3) * 32'h1234_5678 + mo[1]);
        to_rel(1);
        push_coh("R8");

        // R8: offset upset repaired
        to_rel(2);
        force_wr(2, 1, 32'h0);
        to_rel(5);
        check32("R8", "corrupted offset visible", ph(2), ph(3) * mf[2]);
        to_rel(1);
        push_coh("R8");

        // R9: amplitude scrub with DDS on
        to_rel(2);
        force_wr(0, 2, 32'h0000_DEAD);
        to_rel(5);
        check32("R9", "corrupted amp visible", 32'(am(0)), 32'h0000_DEAD);
        to_rel(1);
        check32("R9", "amp restored", 32'(am(0)), 32'(ma[0]));

        // R11 / R12: shared counter upset, one-cycle latency
        to_rel(2);
        force_wr(4, 0, 32'h1000_0000);
        @(negedge clk);
        check32("R12", "probe one cycle after force", ph(3), 32'h1000_0000);
        push_coh("R11");
        @(negedge clk);
        push_coh("R11");

        // R5: private accumulators
        mode_wr(4'b1100);
        repeat (3) @(negedge clk);
        for (int k = 0; k < NCH; k++) a[k] = ph(k);
        @(negedge clk);
        for (int k = 0; k < NCH; k++) check32("R5", $sformatf("acc step ch%0d", k), ph(k) - a[k], mf[k]);

        // R10: counter keeps running with clear bit 0
        mode_wr(4'b0110);
        repeat (2) @(negedge clk);
        check32("R10", "counter not cleared", 32'(ph(3) > 32'd16), 32'd1);

        // R9: no amplitude scrub with DDS off
        to_rel(2);
        force_wr(1, 2, 32'h0000_BEEF);
        to_rel(1);
        check32("R9", "amp kept, dds off", 32'(am(1)), 32'h0000_BEEF);
        to_rel(1);
        check32("R9", "amp kept, second sync", 32'(am(1)), 32'h0000_BEEF);

        // R10: clear on sync
        mode_wr(4'b0111);
        to_rel(0);
        for (int r = 0; r < P; r++) begin
            check32("R10", $sformatf("probe at %0d", r), ph(3), 32'(r));
            if (r == 3) push_coh("R10");
            @(negedge clk);
        end

        // R6: period 0 leaves an upset in place
        mode_wr(4'b0110);
        sync_period = 16'd0;
        @(negedge clk);
        force_wr(0, 0, 32'd5);
        repeat (40) @(negedge clk);
        check32("R6", "no repair with period 0", ph(0), ph(3) * 32'd5 + mo[0]);

        @(negedge clk);
        summary();
        $finish;
    end

endmodule